// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a bank of 32-bit configuration registers on a simple word-addressed request/response bus with a 4 KiB byte-addressed window. Software must open a guard before it can change ordinary registers. Writing a 16-bit opening key to one offset opens the guard, and writing a different 16-bit closing key to another offset closes it. The bank leaves reset closed. While the guard is closed, writes to protected registers are dropped and flagged as errors. A one-bit scratch cell and the two key offsets stay writable at all times.

Every offset has its own direction policy: read/write, read-only, write-only or unmapped. An access in a direction the offset does not allow, an access to an unmapped offset and a misaligned address all return an error pulse with the response. Such an access changes no state, and when it is a read it returns zero. The stored registers are three oscillator-control words, a serial-clock control word, a soft-reset control word and a parameterized run of generic words. A set of read-only words holds constant status and identity values. An accepted write that sets bit 0 of the soft-reset word sends a one-cycle reset request to the system.

Each request is answered exactly one cycle later with registered data and error flags. The registers only store values and drive nothing else.

Top module: `keyed_cfg_bank`

## Requirements
- R1: After reset, the lock status (0x00C, bit 0) reads 1. The words 0x100, 0x104 and 0x108 read 0x0001A008. Word 0x10C reads 0x0000003F and word 0x154 reads 0x00003F03. Word 0x25C reads 0x00000001 and word 0x530 reads the ID_VALUE parameter. Word 0x000, word 0x200 and the generic words read 0. No response is pending and no reset request is active.
- R2: A write to 0x004 whose bits [15:0] equal 0x767B sets the lock status to 1, whatever bits [31:16] hold. Any other value written there leaves the lock status unchanged. Writes to 0x004 never raise an error.
- R3: A write to 0x008 whose bits [15:0] equal 0xDF0D clears the lock status to 0. Any other value leaves it unchanged. Writes to 0x008 never raise an error.
- R4: While the lock status is 1, a write to any read/write or write-only offset other than 0x000, 0x004 and 0x008 is discarded and returns rsp_err = 1.
- R5: The scratch word at 0x000 keeps only bit 0 of a write and reads back as that bit zero-extended. It accepts writes while the bank is locked.
- R6: The write-only offsets 0x004, 0x008, 0x60C and 0x614 return data 0 with rsp_err = 1 when read.
- R7: The read-only offsets 0x00C, 0x10C, 0x25C and 0x530 return rsp_err = 1 on a write, and the write leaves every readable value unchanged.
- R8: An access to an unmapped offset, or to an address with bits [1:0] not zero, returns rsp_err = 1 and changes no state. A read of such an address returns 0.
- R9: While unlocked, a write to a read/write offset stores all 32 bits with rsp_err = 0, and a later read returns the value with rsp_err = 0.
- R10: An accepted write to 0x200 with bit 0 set raises sys_rst_req for exactly the response cycle. A write with bit 0 clear, or a write that is rejected, raises no request.
- R11: rsp_valid is 1 exactly one cycle after each cycle with req_valid = 1. rsp_err, rsp_rdata and sys_rst_req are 0 whenever rsp_valid is 0.
- R12: The N_GEN generic words starting at byte offset GEN_BASE (0x700 by default) are read/write words that reset to GEN_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data, 0 for writes and rejected reads |
| rsp_err | output | 1 | Access rejected (direction, mapping, alignment or lock) |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The lock transition and a protected write can land on back-to-back cycles. The write in the cycle right after an opening or closing key must already see the new lock state. To provoke this, the bench issues key writes, protected writes and read-backs with no idle cycle between them. It judges the error flag and the stored value against a bench-side model whose lock bit is updated access by access. The soft-reset request and the access response also share a cycle. The bench checks that the pulse appears only together with an error-free response and is gone in the next idle cycle.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SCRATCH, SEL_LOCK, SEL_UNLOCK, SEL_LOCKSTA,
    SEL_CTL, SEL_PLLSTA, SEL_BOOT, SEL_IDCODE, SEL_CMD
  } sel_e;

  localparam int CTL_IDX_W = 8;

  typedef struct packed {
    acc_e                 acc;
    sel_e                 sel;
    logic [CTL_IDX_W-1:0] ctl_idx;
    logic                 lock_exempt;
    logic                 soft_rst;
  } dec_t;

  // byte offsets whose positions software depends on
  localparam int OFS_SCRATCH = 'h000;
  localparam int OFS_LOCK    = 'h004;
  localparam int OFS_UNLOCK  = 'h008;
  localparam int OFS_LOCKSTA = 'h00C;
  localparam int OFS_PLL0    = 'h100;
  localparam int OFS_PLLSTA  = 'h10C;
  localparam int OFS_UARTCLK = 'h154;
  localparam int OFS_SOFTRST = 'h200;
  localparam int OFS_BOOT    = 'h25C;
  localparam int OFS_IDCODE  = 'h530;
  localparam int OFS_CMD_A   = 'h60C;
  localparam int OFS_CMD_B   = 'h614;

  // slots in the control storage
  localparam int N_PLL       = 3;
  localparam int CTL_UART    = 3;
  localparam int CTL_SOFTRST = 4;
  localparam int CTL_GEN0    = 5;

endpackage

// File: rtl/keyed_cfg_decode.sv
module keyed_cfg_decode
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int N_GEN    = 8,
  parameter int GEN_BASE = 'h700
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] PLL_LO = WORD_W'(OFS_PLL0 / 4);
  localparam logic [WORD_W-1:0] PLL_HI = WORD_W'(OFS_PLL0 / 4 + N_PLL);
  localparam logic [WORD_W-1:0] GEN_LO = WORD_W'(GEN_BASE / 4);
  localparam logic [WORD_W-1:0] GEN_HI = WORD_W'(GEN_BASE / 4 + N_GEN);

  function automatic logic [WORD_W-1:0] w_of(input int byte_ofs);
    return WORD_W'(byte_ofs / 4);
  endfunction

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    dec = '{acc: ACC_NONE, sel: SEL_NONE, ctl_idx: '0,
            lock_exempt: 1'b0, soft_rst: 1'b0};
    if (addr[1:0] == 2'b00) begin
      if (word == w_of(OFS_SCRATCH)) begin
        dec.acc = ACC_RW; dec.sel = SEL_SCRATCH; dec.lock_exempt = 1'b1;
      end else if (word == w_of(OFS_LOCK)) begin
        dec.acc = ACC_WO; dec.sel = SEL_LOCK; dec.lock_exempt = 1'b1;
      end else if (word == w_of(OFS_UNLOCK)) begin
        dec.acc = ACC_WO; dec.sel = SEL_UNLOCK; dec.lock_exempt = 1'b1;
      end else if (word == w_of(OFS_LOCKSTA)) begin
        dec.acc = ACC_RO; dec.sel = SEL_LOCKSTA;
      end else if (word >= PLL_LO && word < PLL_HI) begin
        dec.acc = ACC_RW; dec.sel = SEL_CTL;
        dec.ctl_idx = CTL_IDX_W'(word - PLL_LO);
      end else if (word == w_of(OFS_PLLSTA)) begin
        dec.acc = ACC_RO; dec.sel = SEL_PLLSTA;
      end else if (word == w_of(OFS_UARTCLK)) begin
        dec.acc = ACC_RW; dec.sel = SEL_CTL;
        dec.ctl_idx = CTL_IDX_W'(CTL_UART);
      end else if (word == w_of(OFS_SOFTRST)) begin
        dec.acc = ACC_RW; dec.sel = SEL_CTL; dec.soft_rst = 1'b1;
        dec.ctl_idx = CTL_IDX_W'(CTL_SOFTRST);
      end else if (word == w_of(OFS_BOOT)) begin
        dec.acc = ACC_RO; dec.sel = SEL_BOOT;
      end else if (word == w_of(OFS_IDCODE)) begin
        dec.acc = ACC_RO; dec.sel = SEL_IDCODE;
      end else if (word == w_of(OFS_CMD_A) || word == w_of(OFS_CMD_B)) begin
        dec.acc = ACC_WO; dec.sel = SEL_CMD;
      end else if (word >= GEN_LO && word < GEN_HI) begin
        dec.acc = ACC_RW; dec.sel = SEL_CTL;
        dec.ctl_idx = CTL_IDX_W'(CTL_GEN0) + CTL_IDX_W'(word - GEN_LO);
      end
    end
  end
endmodule

// File: rtl/keyed_cfg_lock.sv
module keyed_cfg_lock #(
  parameter int              KEY_W      = 16,
  parameter logic [KEY_W-1:0] CLOSE_KEY = 16'h767B,
  parameter logic [KEY_W-1:0] OPEN_KEY  = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_wr,
  input  logic             unlock_wr,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst) locked_q <= 1'b1;
    else if (lock_wr && key == CLOSE_KEY) locked_q <= 1'b1;
    else if (unlock_wr && key == OPEN_KEY) locked_q <= 1'b0;
  end

  assign locked = locked_q;

  AST_LOCK_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (rst)
    !$stable(locked_q) |-> $past(lock_wr || unlock_wr)); // R2
  AST_OPEN_KEY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (unlock_wr && key == OPEN_KEY) |=> !locked_q); // R3
endmodule

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs
  import keyed_cfg_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                N_CTL    = 13,
  parameter logic [DATA_W-1:0] PLL_RST  = 32'h0001_A008,
  parameter logic [DATA_W-1:0] UART_RST = 32'h0000_3F03,
  parameter logic [DATA_W-1:0] GEN_RST  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CTL_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CTL_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data
);
  function automatic logic [DATA_W-1:0] rst_val(input int i);
    if (i < N_PLL)            return PLL_RST;
    else if (i == CTL_UART)    return UART_RST;
    else if (i == CTL_SOFTRST) return '0;
    else                       return GEN_RST;
  endfunction

  logic [DATA_W-1:0] ctl_q [N_CTL];

  for (genvar i = 0; i < N_CTL; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) ctl_q[i] <= rst_val(i);
      else if (wr_en && wr_idx == CTL_IDX_W'(i)) ctl_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CTL; i++)
      if (rd_idx == CTL_IDX_W'(i)) rd_data = ctl_q[i];
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < N_CTL)); // R9
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import keyed_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter int                KEY_W     = 16,
  parameter int                N_GEN     = 8,
  parameter int                GEN_BASE  = 'h700,
  parameter logic [DATA_W-1:0] GEN_RST   = '0,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h1A2B_0093,
  parameter logic [DATA_W-1:0] BOOT_VAL  = 32'h0000_0001,
  parameter logic [DATA_W-1:0] PLLSTA_VAL = 32'h0000_003F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              sys_rst_req
);
  localparam int N_CTL = CTL_GEN0 + N_GEN;

  dec_t              dec;
  logic              locked;
  logic              scratch_q;
  logic [DATA_W-1:0] ctl_rd;

  keyed_cfg_decode #(.ADDR_W(ADDR_W), .N_GEN(N_GEN), .GEN_BASE(GEN_BASE))
    u_dec (.addr(req_addr), .dec(dec));

  // direction and lock policy
  logic dir_ok, lock_block, commit, err_d, is_rd;
  assign is_rd      = req_valid && !req_write;
  assign dir_ok     = (dec.acc == ACC_RW) ||
                      (dec.acc == ACC_RO && !req_write) ||
                      (dec.acc == ACC_WO &&  req_write);
  assign lock_block = req_write && locked && !dec.lock_exempt;
  assign err_d      = req_valid && (!dir_ok || lock_block);
  assign commit     = req_valid && req_write && dir_ok && !lock_block;

  logic ctl_we, rst_req_d;
  assign ctl_we    = commit && dec.sel == SEL_CTL;
  assign rst_req_d = ctl_we && dec.soft_rst && req_wdata[0];

  keyed_cfg_lock #(.KEY_W(KEY_W)) u_lock (
    .clk(clk), .rst(rst),
    .lock_wr(commit && dec.sel == SEL_LOCK),
    .unlock_wr(commit && dec.sel == SEL_UNLOCK),
    .key(req_wdata[KEY_W-1:0]),
    .locked(locked));

  keyed_cfg_regs #(.DATA_W(DATA_W), .N_CTL(N_CTL), .GEN_RST(GEN_RST)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(ctl_we), .wr_idx(dec.ctl_idx), .wr_data(req_wdata),
    .rd_idx(dec.ctl_idx), .rd_data(ctl_rd));

  always_ff @(posedge clk) begin
    if (rst) scratch_q <= 1'b0;
    else if (commit && dec.sel == SEL_SCRATCH) scratch_q <= req_wdata[0];
  end

  logic [DATA_W-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (is_rd && dir_ok) begin
      unique case (dec.sel)
        SEL_SCRATCH: rdata_d = DATA_W'(scratch_q);
        SEL_LOCKSTA: rdata_d = DATA_W'(locked);
        SEL_CTL:     rdata_d = ctl_rd;
        SEL_PLLSTA:  rdata_d = PLLSTA_VAL;
        SEL_BOOT:    rdata_d = BOOT_VAL;
        SEL_IDCODE:  rdata_d = ID_VALUE;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= rdata_d;
      rsp_err     <= err_d;
      sys_rst_req <= rst_req_d;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_err && rsp_rdata == '0 && !sys_rst_req)); // R11
  AST_LOCKED_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && locked && dec.acc != ACC_NONE &&
     !dec.lock_exempt) |=> rsp_err); // R4
  AST_RST_CLEAN: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> (rsp_valid && !rsp_err)); // R10
endmodule

// File: tb/keyed_cfg_bank_tb_top.sv
module keyed_cfg_bank_tb_top;
  localparam logic [31:0] ID_V = 32'h1A2B_0093;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, sys_rst_req;
  logic [31:0] rsp_rdata;

  always #10 clk = ~clk;  // 50 MHz

  keyed_cfg_bank #(.ID_VALUE(ID_V)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sys_rst_req(sys_rst_req));

  int n_chk = 0, n_err = 0, cyc = 0;
  logic        m_locked;
  logic [31:0] shadow [1024];

  // 0 unmapped, 1 read/write, 2 read-only, 3 write-only
  function automatic int kind(input int w);
    if (w == 0 || w == 'h40 || w == 'h41 || w == 'h42 || w == 'h55 ||
        w == 'h80 || (w >= 'h1C0 && w < 'h1C8)) return 1;
    if (w == 3 || w == 'h43 || w == 'h97 || w == 'h14C) return 2;
    if (w == 1 || w == 2 || w == 'h183 || w == 'h185) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] rd_exp(input int w);
    if (w == 3)     return {31'd0, m_locked};
    if (w == 'h43)  return 32'h3F;
    if (w == 'h97)  return 32'h1;
    if (w == 'h14C) return ID_V;
    if (kind(w) == 1) return shadow[w];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        g_v, g_e, g_r;
  logic [31:0] g_d;

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    g_v = rsp_valid; g_e = rsp_err; g_d = rsp_rdata; g_r = sys_rst_req;
  endtask

  // model-checked aligned access
  task automatic macc(input bit wr, input int w, input logic [31:0] d, input string tag);
    int k; bit e_err; bit e_rst; logic [31:0] e_dat;
    k = kind(w);
    e_rst = 1'b0; e_dat = 32'h0;
    if (wr) e_err = (k == 0) || (k == 2) || (m_locked && w > 2);
    else    e_err = (k == 0) || (k == 3);
    if (!wr && !e_err) e_dat = rd_exp(w);
    if (wr && !e_err) begin
      if (w == 'h80 && d[0]) e_rst = 1'b1;
    end
    access(wr, 12'(w * 4), d);
    check({g_v, g_e, g_r, g_d} === {1'b1, e_err, e_rst, e_dat}, tag,
          {29'd0, g_v, g_e, g_r, g_d}, {29'd0, 1'b1, e_err, e_rst, e_dat});
    if (wr && !e_err) begin
      if (w == 0) shadow[0] = {31'd0, d[0]};
      else if (k == 1) shadow[w] = d;
      if (w == 1 && d[15:0] == 16'h767B) m_locked = 1'b1;
      if (w == 2 && d[15:0] == 16'hDF0D) m_locked = 1'b0;
    end
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    check({rsp_valid, rsp_err, sys_rst_req, rsp_rdata} === 35'd0, tag,
          {29'd0, rsp_valid, rsp_err, sys_rst_req, rsp_rdata}, 64'd0);
  endtask

  task automatic read_sweep(input string tag);
    for (int w = 0; w < 1024; w++) macc(1'b0, w, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    m_locked = 1'b1;
    for (int w = 0; w < 1024; w++) shadow[w] = 32'h0;
    shadow['h40] = 32'h0001_A008; shadow['h41] = 32'h0001_A008;
    shadow['h42] = 32'h0001_A008; shadow['h55] = 32'h0000_3F03;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check({rsp_valid, rsp_err, sys_rst_req} === 3'b000, "R1 idle after reset",
          {61'd0, rsp_valid, rsp_err, sys_rst_req}, 64'd0);

    // reset values, direction policy on reads
    read_sweep("R1/R6/R7/R8/R12 reset sweep");

    // locked writes everywhere; keys never match (low16 = word index)
    for (int w = 0; w < 1024; w++)
      macc(1'b1, w, 32'h5A5A_0000 | 32'(w), "R4/R5/R7/R8 locked write");
    read_sweep("R4/R5/R7 locked readback");
    idle_chk("R11 idle after sweep");

    // key handling, back to back
    macc(1'b1, 2, 32'h0000_DF0C, "R3 wrong open key");
    macc(1'b0, 3, 32'h0, "R3 still locked");
    macc(1'b1, 2, 32'hABCD_DF0D, "R3 open key");
    macc(1'b0, 3, 32'h0, "R3 unlocked status");
    macc(1'b1, 1, 32'hFFFF_767A, "R2 wrong close key");
    macc(1'b0, 3, 32'h0, "R2 still unlocked");
    macc(1'b1, 1, 32'h1234_767B, "R2 close key");
    macc(1'b1, 'h41, 32'hDEAD_BEEF, "R4 write right after close");
    macc(1'b0, 'h41, 32'h0, "R4 value kept");
    macc(1'b1, 0, 32'hFFFF_FFFF, "R5 scratch while locked");
    macc(1'b0, 0, 32'h0, "R5 scratch bit0 only");
    macc(1'b1, 2, 32'h0000_DF0D, "R3 reopen");
    macc(1'b1, 'h41, 32'hCAFE_F00D, "R9 write right after open");
    macc(1'b0, 'h41, 32'h0, "R9 readback");

    // misaligned
    access(1'b0, 12'h101, 32'h0);
    check({g_v, g_e, g_d} === {2'b11, 32'h0}, "R8 misaligned read",
          {30'd0, g_v, g_e, g_d}, {30'd0, 2'b11, 32'h0});
    access(1'b1, 12'h102, 32'h1111_1111);
    check({g_v, g_e} === 2'b11, "R8 misaligned write",
          {62'd0, g_v, g_e}, 64'd3);
    macc(1'b0, 'h40, 32'h0, "R8 no change after misaligned");

    // unlocked writes everywhere (low16 = w<<4, never a key, bit0 clear)
    for (int w = 0; w < 1024; w++)
      macc(1'b1, w, 32'hC300_0000 | 32'(w << 4), "R7/R8/R9/R12 open write");
    read_sweep("R9/R12 open readback");

    // soft reset request
    macc(1'b1, 'h80, 32'h0000_0003, "R10 soft reset pulse");
    idle_chk("R10 pulse ends");
    macc(1'b1, 'h80, 32'h0000_0002, "R10 bit0 clear no pulse");
    macc(1'b1, 'h80, 32'h0000_0001, "R10 back-to-back pulse");
    macc(1'b1, 1, 32'h0000_767B, "R2 close before reset test");
    macc(1'b1, 'h80, 32'h0000_0001, "R10 locked no pulse");
    macc(1'b0, 'h80, 32'h0, "R10 value kept when locked");
    idle_chk("R11 final idle");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule